// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Unit

This block keeps one 32-bit control and status word for each channel of a multi-channel DMA controller. Software reaches each word through a simple register port with full-word accesses. The transfer engine and the request logic report channel events as one-cycle pulses. The block sets the matching status bits, works out a gated cause bit for each channel, and merges all channels into one level interrupt.

Software sets run and the interrupt enables by writing a channel word. Status bits are cleared by writing ones to them. The compare-status flag has its own set and clear command bits. A read returns the stored word plus a live request-pending bit. One extra register returns the summary vector, one bit per channel. The block moves no data and fetches no descriptors. It only holds state and signals software.

Top module: `dma_stat_irq_unit`

## Requirements
- R1: After reset every channel word reads 0x00000008 (only the stop status bit, bit 3, is set). `irq_o`, `run_o` and `summary_o` are all 0.
- R2: A write to channel n (byte offset 4·n) keeps status bits 0..4, 9 and 10 of the old word and drops every other status bit. Of the kept bits, bus error (0), start (1), end (2) and end-of-request (9) are cleared wherever the written value has a 1. Stop (3), request-after-stop (4) and compare status (10) are not cleared by a 1.
- R3: A channel write copies written bits 31..26 and 23 into the word. These bits are run (31), no-descriptor-fetch (30), stop enable (29), end-of-request enable (28), end-of-request jump enable (27), end-of-request stop enable (26) and request-after-stop enable (23). Bits 5..7, 11..22, 24 and 25 are never stored and read as 0.
- R4: Written bit 24 clears compare status (bit 10) and written bit 25 sets it. When both are 1, the set wins.
- R5: A write with run (bit 31) set clears stop status. A write with both run and mask-run (bit 22) at 0 sets stop status. A write with only mask-run set leaves stop status unchanged.
- R6: A read of channel n returns its word with bit 8 equal to `req_active[n]`. A read of an offset that maps to no register returns 0.
- R7: Event pulses set their bits in the next cycle: start to bit 1, end to bit 2, stop to bit 3, request-after-stop to bit 4, end-of-request to bit 9. An event wins over a software write that clears the same bit in the same cycle.
- R8: The cause bit of channel n is (stop AND bit 29) OR (end-of-request AND bit 28) OR (request-after-stop AND bit 23) OR start OR end. The cause bits drive `summary_o`, and a read of byte offset 0xF0 returns them zero-extended to 32 bits. Writes to 0xF0 change nothing.
- R9: `irq_o` is the OR of all cause bits, registered: it follows any state change one cycle later.
- R10: `run_o[n]` equals bit 31 of channel n's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wen | input | 1 | Full-word write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_start | input | NUM_CH | Start event pulse per channel |
| ev_end | input | NUM_CH | End event pulse per channel |
| ev_stop | input | NUM_CH | Stop event pulse per channel |
| ev_eor | input | NUM_CH | End-of-request event pulse per channel |
| ev_ras | input | NUM_CH | Request-after-stop event pulse per channel |
| req_active | input | NUM_CH | Live peripheral request per channel |
| run_o | output | NUM_CH | Run flag per channel |
| summary_o | output | NUM_CH | Gated cause bit per channel |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions check these rules on every cycle:
- a write with run set leaves the run output high;
- a write without run or mask-run leaves stop status set;
- the compare-set command wins over clear;
- every end event leaves the end bit set;
- an idle channel keeps its word;
- the interrupt trails the OR of the cause bits by one cycle.

Only the bench's scenarios can show the rest, because they compare whole read words with a bench model:
- the exact set of kept, cleared and stored bits for every single-bit write pattern;
- the live request-pending bit;
- the cause gating for each event kind;
- an event beating a clear in the same cycle.

// File: rtl/dma_stat_pkg.sv
// Package: bit positions and masks of the channel control/status word.
// Assumes a 32-bit word; the positions are fixed because software decodes them.
package dma_stat_pkg;
    localparam int WORD_W      = 32;
    localparam int B_BUSERR    = 0;
    localparam int B_START     = 1;
    localparam int B_END       = 2;
    localparam int B_STOP      = 3;
    localparam int B_RAS       = 4;
    localparam int B_REQPEND   = 8;
    localparam int B_EOR       = 9;
    localparam int B_CMP       = 10;
    localparam int B_MASKRUN   = 22;
    localparam int B_RAS_EN    = 23;
    localparam int B_CMP_CLR   = 24;
    localparam int B_CMP_SET   = 25;
    localparam int B_EOR_JMP   = 27;
    localparam int B_EOR_IEN   = 28;
    localparam int B_STOP_IEN  = 29;
    localparam int B_RUN       = 31;

    localparam logic [WORD_W-1:0] KEEP_MASK = 32'h0000_071F;
    localparam logic [WORD_W-1:0] W1C_MASK  = (32'h1 << B_BUSERR) | (32'h1 << B_START)
                                            | (32'h1 << B_END) | (32'h1 << B_EOR);
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'hFC80_0000;
endpackage

// File: rtl/dma_chan_word.sv
// Module: one channel's control/status word.
// Applies software writes (clear-on-one, control copy, compare commands,
// stop rule), then merges engine events, which win over same-cycle clears.
// Also computes the channel's gated interrupt cause. Assumes one-cycle event pulses.
module dma_chan_word
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ev_start,
    input  logic              ev_end,
    input  logic              ev_stop,
    input  logic              ev_eor,
    input  logic              ev_ras,
    output logic [WORD_W-1:0] word_o,
    output logic              run_o,
    output logic              cause_o
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    // Next word: software update first, then events set their bits.
    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = (word_q & KEEP_MASK) & ~(wdata & W1C_MASK);
            word_d = word_d | (wdata & CTRL_MASK);
            if (wdata[B_RUN]) begin
                word_d[B_STOP] = 1'b0;
            end else if (!wdata[B_MASKRUN]) begin
                word_d[B_STOP] = 1'b1;
            end
            if (wdata[B_CMP_CLR]) word_d[B_CMP] = 1'b0;
            if (wdata[B_CMP_SET]) word_d[B_CMP] = 1'b1;
        end
        if (ev_start) word_d[B_START] = 1'b1;
        if (ev_end)   word_d[B_END]   = 1'b1;
        if (ev_stop)  word_d[B_STOP]  = 1'b1;
        if (ev_eor)   word_d[B_EOR]   = 1'b1;
        if (ev_ras)   word_d[B_RAS]   = 1'b1;
    end

    // Word register; reset leaves only stop status set.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= WORD_W'(1) << B_STOP;
        else        word_q <= word_d;
    end

    // Gated cause: three enabled causes plus two ungated ones.
    always_comb begin
        cause_o = (word_q[B_STOP] & word_q[B_STOP_IEN])
                | (word_q[B_EOR]  & word_q[B_EOR_IEN])
                | (word_q[B_RAS]  & word_q[B_RAS_EN])
                | word_q[B_START] | word_q[B_END];
    end

    assign word_o = word_q;
    assign run_o  = word_q[B_RUN];

    assert_run_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_RUN] |=> run_o);
    assert_stop_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wdata[B_RUN] && !wdata[B_MASKRUN] |=> word_o[B_STOP]);
    assert_cmp_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[B_CMP_SET] |=> word_o[B_CMP]);
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_end |=> word_o[B_END]);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !ev_start && !ev_end && !ev_stop && !ev_eor && !ev_ras
        |=> $stable(word_o));
endmodule

// File: rtl/dma_irq_merge.sv
// Module: registers the OR of all channel cause bits into one level interrupt.
// Assumes the causes come from registered state, so one flop gives a clean line.
module dma_irq_merge #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cause_i,
    output logic              irq_o
);
    // Interrupt flop: follows any cause one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |cause_i;
    end

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|cause_i)));
endmodule

// File: rtl/dma_stat_irq_unit.sv
// Module: top of the DMA channel status and interrupt unit.
// Channel n sits at byte offset 4*n and the summary at SUMM_OFF. Assumes
// full-word accesses and NUM_CH <= 32, so the channels stay below SUMM_OFF.
module dma_stat_irq_unit
    import dma_stat_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_stop,
    input  logic [NUM_CH-1:0] ev_eor,
    input  logic [NUM_CH-1:0] ev_ras,
    input  logic [NUM_CH-1:0] req_active,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] summary_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] SUMM_OFF = ADDR_W'('hF0);

    logic [NUM_CH-1:0][WORD_W-1:0] words;
    logic [NUM_CH-1:0]             wr_sel;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            // Write decode for this channel's word offset.
            assign wr_sel[g] = reg_wen && (reg_addr == ADDR_W'(4 * g));

            dma_chan_word u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_sel[g]),
                .wdata    (reg_wdata),
                .ev_start (ev_start[g]),
                .ev_end   (ev_end[g]),
                .ev_stop  (ev_stop[g]),
                .ev_eor   (ev_eor[g]),
                .ev_ras   (ev_ras[g]),
                .word_o   (words[g]),
                .run_o    (run_o[g]),
                .cause_o  (summary_o[g])
            );
        end
    endgenerate

    dma_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (summary_o),
        .irq_o   (irq_o)
    );

    // Read mux: channel words with live request bit, summary, else zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SUMM_OFF) reg_rdata = 32'(summary_o);
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(4 * i)) begin
                reg_rdata = words[i];
                reg_rdata[B_REQPEND] = req_active[i];
            end
        end
    end

    assert_wsel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: tb/dma_stat_irq_unit_test.sv
module dma_stat_irq_unit_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic [7:0]     reg_addr;
    logic           reg_wen;
    logic [31:0]    reg_wdata;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] ev_start, ev_end, ev_stop, ev_eor, ev_ras, req_active;
    logic [NCH-1:0] run_o, summary_o;
    logic           irq_o;

    dma_stat_irq_unit #(.NUM_CH(NCH), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_start(ev_start),
        .ev_end(ev_end), .ev_stop(ev_stop), .ev_eor(ev_eor), .ev_ras(ev_ras),
        .req_active(req_active), .run_o(run_o), .summary_o(summary_o), .irq_o(irq_o)
    );

    logic [31:0] m_word [NCH];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic cause_of(input logic [31:0] s);
        return (s[3] & s[29]) | (s[9] & s[28]) | (s[4] & s[23]) | s[1] | s[2];
    endfunction

    function automatic logic [NCH-1:0] m_summary();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = cause_of(m_word[i]);
        return v;
    endfunction

    // Bench model of a channel write (R2..R5).
    function automatic logic [31:0] m_write(input logic [31:0] old, input logic [31:0] v);
        logic [31:0] s;
        s = (old & 32'h0000071F) & ~(v & 32'h00000207);
        s = s | (v & 32'hFC800000);
        if (v[31]) s[3] = 1'b0;
        else if (!v[22]) s[3] = 1'b1;
        if (v[24]) s[10] = 1'b0;
        if (v[25]) s[10] = 1'b1;
        return s;
    endfunction

    // Reads every channel word plus the summary register and compares them with the model.
    task automatic check_all(input string tag);
        for (int i = 0; i < NCH; i++) begin
            reg_addr = 8'(4 * i);
            #1;
            chk(tag, reg_rdata, m_word[i] | (32'(req_active[i]) << 8));
            chk({tag, " R10"}, 32'(run_o[i]), 32'(m_word[i][31]));
        end
        reg_addr = 8'hF0;
        #1;
        chk({tag, " R8"}, reg_rdata, 32'(m_summary()));
        chk({tag, " R8 port"}, 32'(summary_o), 32'(m_summary()));
    endtask

    // One access and event cycle, then checks of the state, then of the interrupt one cycle later.
    task automatic step(input string tag, input logic wen, input logic [7:0] addr,
                        input logic [31:0] data, input logic [4:0] kinds,
                        input logic [NCH-1:0] chans);
        @(negedge clk);
        reg_wen = wen; reg_addr = addr; reg_wdata = data;
        ev_start = kinds[0] ? chans : '0;
        ev_end   = kinds[1] ? chans : '0;
        ev_stop  = kinds[2] ? chans : '0;
        ev_ras   = kinds[3] ? chans : '0;
        ev_eor   = kinds[4] ? chans : '0;
        for (int i = 0; i < NCH; i++) begin
            if (wen && addr == 8'(4 * i)) m_word[i] = m_write(m_word[i], data);
            if (chans[i]) begin
                if (kinds[0]) m_word[i][1] = 1'b1;
                if (kinds[1]) m_word[i][2] = 1'b1;
                if (kinds[2]) m_word[i][3] = 1'b1;
                if (kinds[3]) m_word[i][4] = 1'b1;
                if (kinds[4]) m_word[i][9] = 1'b1;
            end
        end
        @(negedge clk);
        reg_wen = 1'b0; ev_start = '0; ev_end = '0; ev_stop = '0; ev_ras = '0; ev_eor = '0;
        check_all(tag);
        @(negedge clk);
        chk({tag, " R9"}, 32'(irq_o), 32'(|m_summary()));
    endtask

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wen = 1'b0; reg_wdata = '0;
        ev_start = '0; ev_end = '0; ev_stop = '0; ev_eor = '0; ev_ras = '0;
        req_active = '0;
        for (int i = 0; i < NCH; i++) m_word[i] = 32'h8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");
        chk("R1 irq", 32'(irq_o), 32'h0);

        // R2 R3 R5: every single-bit write pattern on every channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int b = 0; b < 32; b++) begin
                step("R2 R3 R5 single-bit", 1'b1, 8'(4 * ch), 32'h1 << b, 5'b0, '0);
            end
        end

        // R8 R7: enable gated causes and run, then fire each event kind per channel
        for (int ch = 0; ch < NCH; ch++) begin
            step("R3 enables", 1'b1, 8'(4 * ch), 32'hB0800000, 5'b0, '0);
        end
        for (int k = 0; k < 5; k++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                step("R7 event", 1'b0, 8'h0, 32'h0, 5'(1 << k), NCH'(1 << ch));
                step("R8 gating", 1'b1, 8'(4 * ch), 32'hB0800207, 5'b0, '0);
            end
        end

        // R8: events with enables off only raise ungated causes
        step("R8 no enables", 1'b1, 8'h4, 32'h80000000, 5'b0, '0);
        step("R8 gated off", 1'b0, 8'h0, 32'h0, 5'b11100, 4'b0010);
        step("R8 ungated on", 1'b0, 8'h0, 32'h0, 5'b00001, 4'b0010);

        // R7: end event collides with a clear of the same bit
        step("R7 collide", 1'b1, 8'h8, 32'h80000207, 5'b00010, 4'b0100);
        step("R7 collide eor", 1'b1, 8'h8, 32'h80000207, 5'b10000, 4'b0100);

        // R4: compare-status commands
        step("R4 set", 1'b1, 8'hC, 32'h82000000, 5'b0, '0);
        step("R4 clear", 1'b1, 8'hC, 32'h81000000, 5'b0, '0);
        step("R4 both", 1'b1, 8'hC, 32'h83000000, 5'b0, '0);

        // R5: mask-run alone leaves stop unchanged, with stop set and with stop clear
        step("R5 stop via write", 1'b1, 8'h0, 32'h00000000, 5'b0, '0);
        step("R5 maskrun keep set", 1'b1, 8'h0, 32'h00400000, 5'b0, '0);
        step("R5 run clears", 1'b1, 8'h0, 32'h80000000, 5'b0, '0);
        step("R5 maskrun keep clr", 1'b1, 8'h0, 32'h00400000, 5'b0, '0);

        // R6: live request bit and unmapped offsets
        for (int ch = 0; ch < NCH; ch++) begin
            req_active = NCH'(1 << ch);
            check_all("R6 req");
        end
        req_active = '0;
        reg_addr = 8'h40; #1; chk("R6 unmapped", reg_rdata, 32'h0);
        reg_addr = 8'h02; #1; chk("R6 unaligned", reg_rdata, 32'h0);

        // R8: a write to the summary offset changes nothing
        step("R8 summary write", 1'b1, 8'hF0, 32'hFFFFFFFF, 5'b0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule